// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes frames that a receive path has already accepted and lays them into a circular buffer held in a page-organised packet memory. Pages are 256 bytes. The ring spans from a start page up to, but not including, a stop page. The block owns a current-page pointer that marks where the next frame goes. The host owns a boundary pointer that marks how far it has read. Every stored frame begins with a 4-byte header that holds a status byte, the page where the following frame will begin, and the stored length. The header is written after the payload, because the length is only known once the frame ends.

Bytes arrive one at a time on a valid-qualified stream, with start-of-frame and end-of-frame markers. Before it takes a frame, the block checks that the receiver is running, that the ring is well formed and that enough free space remains. It then writes the payload one byte per clock, wrapping from the stop address back to the start address. Runts are padded with zeros. It writes the header, moves the current page to the next-page value and pulses `frame_done`, which serves as the receive interrupt request. Frames that are refused, or that start while the writer is still busy, produce a `drop` pulse and leave the memory untouched.

The controller has six states. IDLE waits for a start marker. DATA stores payload bytes. SKIP discards the rest of a refused frame. PAD writes filler zeros. HDR writes the four header bytes. DONE commits the new current page. The transitions are as follows. IDLE goes to DATA on an accepted start. IDLE goes to SKIP on a refused start, or stays in IDLE if that byte also ends the frame. An accepted single-byte frame goes from IDLE straight to PAD or HDR. DATA goes to PAD or HDR on the end marker. SKIP goes to IDLE on the end marker. PAD goes to HDR once the minimum length is reached. HDR goes to DONE after the fourth header byte. DONE always returns to IDLE.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `cur_pg` is 0 and `mem_we`, `frame_done` and `drop` are all low.
- R2: A cycle with `cur_load` high makes `cur_pg` equal to `cur_load_pg` on the next cycle. `cur_pg` changes at no other time except on a `frame_done` cycle.
- R3: A start marker seen in IDLE is refused when `halt` is high or when `ring_stop_pg <= ring_start_pg`. A refused start produces one `drop` pulse on the next cycle, and no memory write is made for that frame.
- R4: Free pages are computed as follows. If the current page is below the boundary page, free pages are boundary minus current. Otherwise, free pages are (stop − start) − (current − boundary). The frame is refused, with a `drop` pulse, when free pages × 256 < 1518.
- R5: Payload bytes of an accepted frame are written in arrival order, one per clock, starting at the frame base address + 4. Idle gaps in `in_valid` between bytes are allowed.
- R6: When a frame has fewer than 60 bytes, zero bytes are written after the payload until 60 bytes have been stored.
- R7: After the payload and any padding, the header is written at base+0 to base+3. Byte 0 is the status: bit 0 = 1, and bit 5 = bit 0 of the first frame byte (the group bit), with the other bits 0. Byte 1 is the next page. Byte 2 is the low byte of L and byte 3 is its high byte, where L = stored length + 4.
- R8: The next address is base + ((L + 4 + 255) rounded down to a multiple of 256), reduced by the ring size when it is at or beyond the stop address. One cycle after the last header write, `frame_done` pulses and `cur_pg` takes the next page.
- R9: A payload write that would land on the stop address lands on the start address instead.
- R10: When current page × 256 is at or beyond the packet memory end (`MEM_END_PG` × 256), the frame base is the start address.
- R11: A start marker that arrives in any state other than IDLE produces a `drop` pulse. That frame's bytes are not stored, and the frame in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Receiver stopped; new frames are refused |
| ring_start_pg | input | 8 | First page of the ring |
| ring_stop_pg | input | 8 | Page just past the ring |
| bnry_pg | input | 8 | Host boundary page |
| cur_load | input | 1 | Load strobe for the current page |
| cur_load_pg | input | 8 | Value loaded into the current page |
| in_valid | input | 1 | Stream byte valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Stream byte |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_pg | output | 8 | Current page pointer |
| frame_done | output | 1 | Frame stored; receive interrupt request pulse |
| drop | output | 1 | Frame refused or dropped pulse |

## Verification
The checks rest on several assumptions about the inputs. The ring registers and the boundary stay constant from a frame's start marker until its `frame_done` or `drop`. `cur_load` is not pulsed while a frame is in progress. The current page lies inside the ring or at or beyond the memory end, so every write address falls between the start and stop addresses. The stimulus follows these rules. It changes the ring registers and loads the current page only after the reference model's queue of expected writes, completions and drops has drained. The single exception is the busy-drop case, which deliberately sends a second start marker while the first frame is still padding.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_DATA,
        RX_SKIP,
        RX_PAD,
        RX_HDR,
        RX_DONE
    } rx_state_e;

    localparam int HDR_BYTES = 4;
    localparam int CRC_BYTES = 4;

endpackage

// File: rtl/rxr_room_check.sv
module rxr_room_check #(
    parameter int PG_W       = 8,
    parameter int PAGE_BYTES = 256,
    parameter int MAX_FRAME  = 1514
) (
    input  logic            halt,
    input  logic [PG_W-1:0] start_pg,
    input  logic [PG_W-1:0] stop_pg,
    input  logic [PG_W-1:0] bnry_pg,
    input  logic [PG_W-1:0] cur_pg,
    output logic            refuse
);
    import rxr_pkg::*;

    localparam int NEED_BYTES = MAX_FRAME + HDR_BYTES;

    int ring_pages;
    int free_pages;

    always_comb begin
        ring_pages = int'(stop_pg) - int'(start_pg);
        if (cur_pg < bnry_pg) begin
            free_pages = int'(bnry_pg) - int'(cur_pg);
        end else begin
            free_pages = ring_pages - (int'(cur_pg) - int'(bnry_pg));
        end
        refuse = halt || (stop_pg <= start_pg) || (free_pages * PAGE_BYTES < NEED_BYTES);
    end

endmodule

// File: rtl/rxr_next_page.sv
module rxr_next_page #(
    parameter int PG_W  = 8,
    parameter int OFF_W = 8,
    parameter int LEN_W = 16
) (
    input  logic [PG_W+OFF_W-1:0] base_addr,
    input  logic [LEN_W-1:0]      stored_len,
    input  logic [PG_W-1:0]       start_pg,
    input  logic [PG_W-1:0]       stop_pg,
    output logic [PG_W-1:0]       next_pg,
    output logic [LEN_W-1:0]      tot_len
);
    import rxr_pkg::*;

    localparam int PAGE_BYTES = 1 << OFF_W;

    int          span;
    logic [31:0] nxt;

    always_comb begin
        tot_len = stored_len + LEN_W'(HDR_BYTES);
        span    = ((int'(tot_len) + CRC_BYTES + PAGE_BYTES - 1) / PAGE_BYTES) * PAGE_BYTES;
        nxt     = 32'(int'(base_addr) + span);
        if (nxt >= 32'(int'(stop_pg) * PAGE_BYTES)) begin
            nxt = nxt - 32'((int'(stop_pg) - int'(start_pg)) * PAGE_BYTES);
        end
        next_pg = nxt[OFF_W +: PG_W];
    end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
    parameter int PG_W       = 8,
    parameter int OFF_W      = 8,
    parameter int LEN_W      = 16,
    parameter int MEM_END_PG = 128,
    parameter int MIN_FRAME  = 60,
    parameter int MAX_FRAME  = 1514
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  halt,
    input  logic [PG_W-1:0]       ring_start_pg,
    input  logic [PG_W-1:0]       ring_stop_pg,
    input  logic [PG_W-1:0]       bnry_pg,
    input  logic                  cur_load,
    input  logic [PG_W-1:0]       cur_load_pg,
    input  logic                  in_valid,
    input  logic                  in_sof,
    input  logic                  in_eof,
    input  logic [7:0]            in_data,
    output logic                  mem_we,
    output logic [PG_W+OFF_W-1:0] mem_addr,
    output logic [7:0]            mem_wdata,
    output logic [PG_W-1:0]       cur_pg,
    output logic                  frame_done,
    output logic                  drop
);
    import rxr_pkg::*;

    localparam int ADDR_W       = PG_W + OFF_W;
    localparam int PAGE_BYTES   = 1 << OFF_W;
    localparam int MEM_END_ADDR = MEM_END_PG * PAGE_BYTES;

    rx_state_e         state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] wr_ptr_q;
    logic [LEN_W-1:0]  len_q;
    logic              grp_q;
    logic [1:0]        hcnt_q;
    logic [PG_W-1:0]   cur_q;

    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] stop_addr;
    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W-1:0] first_addr;
    logic              refuse;
    logic [PG_W-1:0]   next_pg;
    logic [LEN_W-1:0]  tot_len;
    logic [7:0]        hdr_byte;
    logic              sof_seen;
    logic              short_after_one;
    logic              short_after_next;

    function automatic logic [ADDR_W-1:0] ring_step(input logic [ADDR_W-1:0] a,
                                                    input logic [ADDR_W-1:0] lo,
                                                    input logic [ADDR_W-1:0] hi);
        logic [ADDR_W-1:0] n;
        n = a + 1'b1;
        if (n == hi) begin
            n = lo;
        end
        return n;
    endfunction

    assign start_addr = {ring_start_pg, {OFF_W{1'b0}}};
    assign stop_addr  = {ring_stop_pg, {OFF_W{1'b0}}};
    assign sof_seen   = in_valid && in_sof;
    assign cur_pg     = cur_q;

    always_comb begin
        if (int'(cur_q) * PAGE_BYTES >= MEM_END_ADDR) begin
            base_sel = start_addr;
        end else begin
            base_sel = {cur_q, {OFF_W{1'b0}}};
        end
        first_addr       = base_sel + ADDR_W'(HDR_BYTES);
        short_after_one  = (1 < MIN_FRAME);
        short_after_next = (int'(len_q) + 1 < MIN_FRAME);
    end

    rxr_room_check #(
        .PG_W       (PG_W),
        .PAGE_BYTES (PAGE_BYTES),
        .MAX_FRAME  (MAX_FRAME)
    ) u_room (
        .halt     (halt),
        .start_pg (ring_start_pg),
        .stop_pg  (ring_stop_pg),
        .bnry_pg  (bnry_pg),
        .cur_pg   (cur_q),
        .refuse   (refuse)
    );

    rxr_next_page #(
        .PG_W  (PG_W),
        .OFF_W (OFF_W),
        .LEN_W (LEN_W)
    ) u_next (
        .base_addr  (base_q),
        .stored_len (len_q),
        .start_pg   (ring_start_pg),
        .stop_pg    (ring_stop_pg),
        .next_pg    (next_pg),
        .tot_len    (tot_len)
    );

    always_comb begin
        unique case (hcnt_q)
            2'd0:    hdr_byte = {2'b00, grp_q, 4'b0000, 1'b1};
            2'd1:    hdr_byte = 8'(next_pg);
            2'd2:    hdr_byte = tot_len[7:0];
            default: hdr_byte = 8'(tot_len >> 8);
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (sof_seen) begin
                    if (refuse) begin
                        state_d = in_eof ? RX_IDLE : RX_SKIP;
                    end else if (in_eof) begin
                        state_d = short_after_one ? RX_PAD : RX_HDR;
                    end else begin
                        state_d = RX_DATA;
                    end
                end
            end
            RX_DATA: begin
                if (in_valid && !in_sof && in_eof) begin
                    state_d = short_after_next ? RX_PAD : RX_HDR;
                end
            end
            RX_SKIP: begin
                if (in_valid && in_eof) begin
                    state_d = RX_IDLE;
                end
            end
            RX_PAD: begin
                if (!short_after_next) begin
                    state_d = RX_HDR;
                end
            end
            RX_HDR: begin
                if (hcnt_q == 2'd3) begin
                    state_d = RX_DONE;
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            wr_ptr_q   <= '0;
            len_q      <= '0;
            grp_q      <= 1'b0;
            hcnt_q     <= 2'd0;
            cur_q      <= '0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            frame_done <= 1'b0;
            drop       <= 1'b0;
        end else begin
            mem_we     <= 1'b0;
            frame_done <= 1'b0;
            drop       <= 1'b0;
            if (cur_load) begin
                cur_q <= cur_load_pg;
            end
            unique case (state_q)
                RX_IDLE: begin
                    if (sof_seen) begin
                        if (refuse) begin
                            drop <= 1'b1;
                        end else begin
                            base_q    <= base_sel;
                            mem_we    <= 1'b1;
                            mem_addr  <= first_addr;
                            mem_wdata <= in_data;
                            wr_ptr_q  <= ring_step(first_addr, start_addr, stop_addr);
                            len_q     <= LEN_W'(1);
                            grp_q     <= in_data[0];
                            hcnt_q    <= 2'd0;
                        end
                    end
                end
                RX_DATA: begin
                    if (sof_seen) begin
                        drop <= 1'b1;
                    end else if (in_valid) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= wr_ptr_q;
                        mem_wdata <= in_data;
                        wr_ptr_q  <= ring_step(wr_ptr_q, start_addr, stop_addr);
                        len_q     <= len_q + 1'b1;
                    end
                end
                RX_SKIP: begin
                    if (sof_seen) begin
                        drop <= 1'b1;
                    end
                end
                RX_PAD: begin
                    if (sof_seen) begin
                        drop <= 1'b1;
                    end
                    mem_we    <= 1'b1;
                    mem_addr  <= wr_ptr_q;
                    mem_wdata <= 8'h00;
                    wr_ptr_q  <= ring_step(wr_ptr_q, start_addr, stop_addr);
                    len_q     <= len_q + 1'b1;
                end
                RX_HDR: begin
                    if (sof_seen) begin
                        drop <= 1'b1;
                    end
                    mem_we    <= 1'b1;
                    mem_addr  <= base_q + ADDR_W'(hcnt_q);
                    mem_wdata <= hdr_byte;
                    hcnt_q    <= hcnt_q + 1'b1;
                end
                default: begin
                    if (sof_seen) begin
                        drop <= 1'b1;
                    end
                    cur_q      <= next_pg;
                    frame_done <= 1'b1;
                end
            endcase
        end
    end

    // Refused starts give a drop and no write (R3)
    a_r3_refuse_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_IDLE && sof_seen && (halt || ring_stop_pg <= ring_start_pg))
        |=> (drop && !mem_we));

    // A start while busy gives a drop (R11)
    a_r11_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RX_IDLE && sof_seen) |=> drop);

    // Padding writes carry zero (R6)
    a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_PAD) |=> (mem_we && mem_wdata == 8'h00));

    // Completion follows the last header write (R8)
    a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(mem_we));

    // Current page moves only on a load or a completion (R2)
    a_r2_cur_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && !$past(cur_load)) |-> $stable(cur_pg));

    // Every write stays inside the ring (R9)
    a_r9_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= start_addr && mem_addr < stop_addr));

endmodule

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b0;
    logic [7:0]  ring_start_pg = 8'h40;
    logic [7:0]  ring_stop_pg = 8'h80;
    logic [7:0]  bnry_pg = 8'h40;
    logic        cur_load = 1'b0;
    logic [7:0]  cur_load_pg = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  cur_pg;
    logic        frame_done;
    logic        drop;

    int checks = 0;
    int fails = 0;
    bit running = 1'b0;

    int m_start = 'h40;
    int m_stop = 'h80;
    int m_bnry = 'h40;
    int m_cur = 0;
    bit m_halt = 1'b0;

    int    exp_addr[$];
    int    exp_data[$];
    string exp_req[$];
    int    exp_cur[$];
    string exp_drop[$];

    always #5 clk = ~clk;

    rx_ring_writer u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .halt          (halt),
        .ring_start_pg (ring_start_pg),
        .ring_stop_pg  (ring_stop_pg),
        .bnry_pg       (bnry_pg),
        .cur_load      (cur_load),
        .cur_load_pg   (cur_load_pg),
        .in_valid      (in_valid),
        .in_sof        (in_sof),
        .in_eof        (in_eof),
        .in_data       (in_data),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .cur_pg        (cur_pg),
        .frame_done    (frame_done),
        .drop          (drop)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Cycle-by-cycle comparison against the expectation queues
    always @(negedge clk) begin
        if (running) begin
            if (mem_we) begin
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R3", "unexpected write addr", int'(mem_addr), -1);
                end else begin
                    int    ea, ed;
                    string er;
                    ea = exp_addr.pop_front();
                    ed = exp_data.pop_front();
                    er = exp_req.pop_front();
                    chk(int'(mem_addr) == ea, er, "write addr", int'(mem_addr), ea);
                    chk(int'(mem_wdata) == ed, er, "write data", int'(mem_wdata), ed);
                end
            end
            if (frame_done) begin
                if (exp_cur.size() == 0) begin
                    chk(1'b0, "R8", "unexpected frame_done", 1, 0);
                end else begin
                    int ec;
                    ec = exp_cur.pop_front();
                    chk(exp_addr.size() == 0, "R8", "writes left at frame_done", exp_addr.size(), 0);
                    chk(int'(cur_pg) == ec, "R8", "cur_pg after frame_done", int'(cur_pg), ec);
                end
            end
            if (drop) begin
                if (exp_drop.size() == 0) begin
                    chk(1'b0, "R11", "unexpected drop", 1, 0);
                end else begin
                    string dr;
                    dr = exp_drop.pop_front();
                    chk(1'b1, dr, "drop", 1, 1);
                end
            end
        end
    end

    task automatic set_ring(input int s, input int e, input int b, input bit h);
        @(negedge clk);
        m_start = s; m_stop = e; m_bnry = b; m_halt = h;
        ring_start_pg = 8'(s);
        ring_stop_pg  = 8'(e);
        bnry_pg       = 8'(b);
        halt          = h;
    endtask

    task automatic load_cur(input int p);
        @(negedge clk);
        cur_load    = 1'b1;
        cur_load_pg = 8'(p);
        @(negedge clk);
        cur_load = 1'b0;
        m_cur = p;
        chk(int'(cur_pg) == p, "R2", "cur_pg after load", int'(cur_pg), p);
    endtask

    task automatic push_wr(input int a, input int d, input string r);
        exp_addr.push_back(a);
        exp_data.push_back(d);
        exp_req.push_back(r);
    endtask

    // Reference model: expected memory image writes for one frame
    task automatic expect_frame(input logic [7:0] fr[$]);
        int avail, idx, n, stored, addr, tot, nxt;
        bit wrapped, remap;
        if (m_halt || m_stop <= m_start) begin
            exp_drop.push_back("R3");
            return;
        end
        if (m_cur < m_bnry) avail = (m_bnry - m_cur) * 256;
        else avail = ((m_stop - m_start) - (m_cur - m_bnry)) * 256;
        if (avail < 1518) begin
            exp_drop.push_back("R4");
            return;
        end
        idx = m_cur * 256;
        remap = 1'b0;
        if (idx >= 128 * 256) begin
            idx = m_start * 256;
            remap = 1'b1;
        end
        n = fr.size();
        stored = (n < 60) ? 60 : n;
        addr = idx + 4;
        wrapped = 1'b0;
        for (int i = 0; i < stored; i++) begin
            if (i < n) push_wr(addr, int'(fr[i]), wrapped ? "R9" : "R5");
            else push_wr(addr, 0, "R6");
            addr++;
            if (addr == m_stop * 256) begin
                addr = m_start * 256;
                wrapped = 1'b1;
            end
        end
        tot = stored + 4;
        nxt = idx + ((tot + 4 + 255) / 256) * 256;
        if (nxt >= m_stop * 256) nxt = nxt - (m_stop - m_start) * 256;
        push_wr(idx, 1 | (int'(fr[0][0]) << 5), remap ? "R10" : "R7");
        push_wr(idx + 1, (nxt / 256) % 256, remap ? "R10" : "R7");
        push_wr(idx + 2, tot % 256, "R7");
        push_wr(idx + 3, (tot / 256) % 256, "R7");
        exp_cur.push_back((nxt / 256) % 256);
        m_cur = (nxt / 256) % 256;
    endtask

    task automatic mk(input int n, input logic [7:0] first, output logic [7:0] q[$]);
        q = {};
        q.push_back(first);
        for (int i = 1; i < n; i++) q.push_back(8'((i * 7 + 3) % 256));
    endtask

    task automatic send(input logic [7:0] fr[$], input bit gaps, input bit busy);
        if (busy) exp_drop.push_back("R11");
        else expect_frame(fr);
        for (int i = 0; i < fr.size(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == fr.size() - 1);
            in_data  = fr[i];
            if (gaps) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sof   = 1'b0;
                in_eof   = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic drain();
        while (exp_addr.size() != 0 || exp_cur.size() != 0 || exp_drop.size() != 0)
            @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] fa[$];
        logic [7:0] fb[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cur_pg == 8'h00, "R1", "cur_pg after reset", int'(cur_pg), 0);
        chk(!mem_we && !frame_done && !drop, "R1", "outputs after reset",
            int'({mem_we, frame_done, drop}), 0);
        running = 1'b1;

        // R5/R7/R8: unicast frame of 100 bytes
        set_ring('h40, 'h80, 'h40, 1'b0);
        load_cur('h46);
        mk(100, 8'h02, fa);
        send(fa, 1'b0, 1'b0);
        drain();

        // R6: short group-addressed frame, padded, status bit 5 set
        mk(10, 8'h01, fa);
        send(fa, 1'b0, 1'b0);
        drain();

        // R6 boundary: exactly 60 bytes, no padding
        mk(60, 8'h04, fa);
        send(fa, 1'b0, 1'b0);
        drain();

        // R5: single-byte frame and frame with idle gaps
        mk(1, 8'h03, fa);
        send(fa, 1'b0, 1'b0);
        drain();
        mk(20, 8'h08, fa);
        send(fa, 1'b1, 1'b0);
        drain();

        // R9: wrap from stop to start
        set_ring('h40, 'h50, 'h4F, 1'b0);
        load_cur('h4F);
        mk(300, 8'h06, fa);
        send(fa, 1'b0, 1'b0);
        drain();
        chk(int'(cur_pg) == 'h41, "R9", "cur_pg after wrapped frame", int'(cur_pg), 'h41);

        // R3: receiver halted, then empty ring
        set_ring('h40, 'h80, 'h40, 1'b1);
        load_cur('h46);
        mk(70, 8'h02, fa);
        send(fa, 1'b0, 1'b0);
        drain();
        set_ring('h50, 'h50, 'h50, 1'b0);
        send(fa, 1'b0, 1'b0);
        drain();
        chk(int'(cur_pg) == 'h46, "R3", "cur_pg after refusals", int'(cur_pg), 'h46);

        // R4: 5 free pages refused, 6 free pages accepted
        set_ring('h40, 'h80, 'h49, 1'b0);
        load_cur('h44);
        mk(80, 8'h02, fa);
        send(fa, 1'b0, 1'b0);
        drain();
        set_ring('h40, 'h80, 'h4A, 1'b0);
        send(fa, 1'b0, 1'b0);
        drain();

        // R10: current page beyond memory end
        set_ring('h40, 'h80, 'h60, 1'b0);
        load_cur('h90);
        mk(64, 8'h02, fa);
        send(fa, 1'b0, 1'b0);
        drain();

        // R11: second start while the first frame is padding
        set_ring('h40, 'h80, 'h40, 1'b0);
        load_cur('h50);
        mk(10, 8'h02, fa);
        mk(3, 8'h05, fb);
        send(fa, 1'b0, 1'b0);
        send(fb, 1'b0, 1'b1);
        drain();
        chk(int'(cur_pg) == 'h51, "R11", "cur_pg after busy drop", int'(cur_pg), 'h51);

        chk(exp_addr.size() == 0, "R8", "writes never seen", exp_addr.size(), 0);
        chk(exp_cur.size() == 0, "R8", "completions never seen", exp_cur.size(), 0);
        chk(exp_drop.size() == 0, "R4", "drops never seen", exp_drop.size(), 0);
        finish_run();
    end

endmodule